// File: doc/BRIEF.md
# Fixed-Period Pulse-Width Generator

This block drives one pulse-width modulated output with a period fixed at 1 ms. A prescaler turns the system clock into 256 ticks per millisecond. An 8-bit phase counter steps on each tick and wraps every period. Two small registers set the waveform. The duty register holds a code from 0 to 255, and the output is high for (code+1)/256 of each period. Bit 7 of the control register switches the pin driver on and off. When the driver is off, the pin is released, and an external pull-down on the board must hold it low.

A host sets both registers through a single-cycle write port and reads them back through a combinational read port. Writes act at once. Nothing waits for a period boundary, so the period in which a write lands may be cut short or stretched. The phase counter runs whether or not the output is enabled. The pin's polarity is always active-high. A reset returns both registers to zero, which leaves the pin released, so the host must write the duty code and the enable bit again after any reset.

The pin is governed by a three-state machine:
- PIN_RELEASED: the driver is off.
- PIN_HIGH: the pin is driven to 1.
- PIN_LOW: the pin is driven to 0.

Its transitions are:
- ENABLE: PIN_RELEASED to PIN_HIGH or PIN_LOW, depending on whether the phase is at or below the code.
- DISABLE: from PIN_HIGH or PIN_LOW back to PIN_RELEASED.
- MATCH_END: PIN_HIGH to PIN_LOW, once the phase passes the code.
- PERIOD_WRAP: PIN_LOW to PIN_HIGH, once the phase is again at or below the code, normally when the phase wraps to 0.

Top module: `fixed_period_pwm`

## Requirements
- R1: After reset, reads of address 0xD8 and of address 0xD2 both return 0x00, and pwm_oe is 0.
- R2: A write to address 0xD8 stores all 8 bits of the duty code, and a read of 0xD8 returns that code.
- R3: At address 0xD2 only bit 7, the enable, can be written. A read of 0xD2 returns the stored enable in bit 7 and zero in bits 6 to 0, whatever was written to them.
- R4: A read of any address other than 0xD2 and 0xD8 returns 0x00. A write to such an address changes neither register.
- R5: While enabled and with the code held at c, any 256×TICK_DIV consecutive clocks contain exactly (c+1)×TICK_DIV clocks with pwm_out high. Code 0 gives one tick of high time per period, and code 255 keeps the output high throughout.
- R6: While bit 7 of 0xD2 is 0, pwm_oe is 0 and pwm_out is 0. While it is 1, pwm_oe is 1.
- R7: A write that clears the enable takes effect on pwm_oe one clock after the write edge, with no wait for the period boundary.
- R8: The period keeps running while the output is disabled. After any disable and re-enable, the rising edges of pwm_out stay aligned to whole multiples of 256×TICK_DIV clocks from the rising edges before the disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, restores register defaults |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| pwm_out | output | 1 | Pin value, active-high |
| pwm_oe | output | 1 | Pin driver enable; 0 releases the pin |

## Verification
The hardest behaviour to reach from the ports is R8, the period that keeps running while the output is disabled. Nothing of the phase counter is visible while pwm_oe is low, so it can only be inferred from where the rising edges fall after the output is switched back on. The stimulus first records the clock count of one rising edge. It then disables the output for an odd number of clocks that shares no factor with the period, re-enables it, and lets a full period pass. The next rising edge must sit a whole number of periods after the recorded one. Random duty codes and random filler in the reserved control bits cover R2, R3 and R5. Codes 0 and 255 are driven directly.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam logic [7:0] ADDR_CTRL  = 8'hD2;
    localparam logic [7:0] ADDR_DUTY  = 8'hD8;
    localparam int         ENABLE_BIT = 7;
    localparam int         PHASE_W    = 8;
    localparam int         TICKS_PER_PERIOD = 1 << PHASE_W;

    typedef enum logic [1:0] {
        PIN_RELEASED = 2'd0,
        PIN_HIGH     = 2'd1,
        PIN_LOW      = 2'd2
    } pin_state_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [7:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic [PHASE_W-1:0] duty_q,
    output logic         en_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_DUTY) duty_q <= wdata[PHASE_W-1:0];
            if (addr == ADDR_CTRL) en_q   <= wdata[ENABLE_BIT];
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == ADDR_DUTY) rdata = duty_q;
        else if (addr == ADDR_CTRL) rdata[ENABLE_BIT] = en_q;
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int TICK_DIV = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase_q
);
    logic tick;

    generate
        if (TICK_DIV > 1) begin : g_prescale
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (!rst_n)            pre_q <= '0;
                else if (pre_q == LAST) pre_q <= '0;
                else                   pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == LAST);
        end else begin : g_direct
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/pwm_pin_fsm.sv
module pwm_pin_fsm
    import pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PHASE_W-1:0] duty,
    input  logic [PHASE_W-1:0] phase,
    output logic               pin_out,
    output logic               pin_oe
);
    pin_state_t state_q, state_d;
    logic in_high_window;

    assign in_high_window = (phase <= duty);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIN_RELEASED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_RELEASED: begin
                if (en) state_d = in_high_window ? PIN_HIGH : PIN_LOW;
            end
            PIN_HIGH: begin
                if (!en)                 state_d = PIN_RELEASED;
                else if (!in_high_window) state_d = PIN_LOW;
            end
            PIN_LOW: begin
                if (!en)                state_d = PIN_RELEASED;
                else if (in_high_window) state_d = PIN_HIGH;
            end
            default: state_d = PIN_RELEASED;
        endcase
    end

    always_comb begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        unique case (state_q)
            PIN_RELEASED: begin
                pin_out = 1'b0;
                pin_oe  = 1'b0;
            end
            PIN_HIGH: begin
                pin_out = 1'b1;
                pin_oe  = 1'b1;
            end
            PIN_LOW: begin
                pin_out = 1'b0;
                pin_oe  = 1'b1;
            end
            default: begin
                pin_out = 1'b0;
                pin_oe  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fixed_period_pwm.sv
module fixed_period_pwm
    import pwm_pkg::*;
#(
    parameter int CLK_HZ = 25_600_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       pwm_out,
    output logic       pwm_oe
);
    localparam int TICK_DIV = CLK_HZ / (TICKS_PER_PERIOD * 1000);

    logic [PHASE_W-1:0] duty_q;
    logic [PHASE_W-1:0] phase_q;
    logic               en_q;

    pwm_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .duty_q (duty_q),
        .en_q   (en_q)
    );

    pwm_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase_q)
    );

    pwm_pin_fsm u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .duty    (duty_q),
        .phase   (phase_q),
        .pin_out (pwm_out),
        .pin_oe  (pwm_oe)
    );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker
    import pwm_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         addr,
    input logic [7:0]         rdata,
    input logic               en_q,
    input logic [PHASE_W-1:0] duty_q,
    input logic [PHASE_W-1:0] phase_q,
    input logic               pwm_out,
    input logic               pwm_oe
);
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_CTRL) |-> (rdata[6:0] == 7'd0));

    assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != ADDR_CTRL && addr != ADDR_DUTY) |-> (rdata == 8'd0));

    assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && duty_q == 8'hFF) |=> pwm_out);

    assert_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!pwm_oe && !pwm_out));

    assert_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> pwm_oe);

    assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (phase_q == $past(phase_q) + 8'd1));
endmodule

bind fixed_period_pwm pwm_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rdata   (rdata),
    .en_q    (en_q),
    .duty_q  (duty_q),
    .phase_q (phase_q),
    .pwm_out (pwm_out),
    .pwm_oe  (pwm_oe)
);

// File: tb/tb_fixed_period_pwm.sv
module tb_fixed_period_pwm;
    localparam int CLK_HZ = 1_024_000;
    localparam int DIV    = 4;
    localparam int PER    = 256 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pwm_out, pwm_oe;

    int total = 0;
    int bad = 0;
    longint cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fixed_period_pwm #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    function automatic int exp_high(input int code);
        return (code + 1) * DIV;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic measure_high(output int n);
        n = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (pwm_oe && pwm_out) n++;
        end
    endtask

    task automatic wait_rise(output longint t);
        logic prev;
        prev = 1'b1;
        t = -1;
        for (int i = 0; i < 3 * PER; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) begin
                t = cyc;
                break;
            end
            prev = pwm_out;
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int n, code, errs;
        logic [7:0] a;
        longint t0, t1;
        void'($urandom(32'h5EED_0042));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_read(8'hD8, rd); check(rd == 8'h00, "R1 duty", rd, 0);
        reg_read(8'hD2, rd); check(rd == 8'h00, "R1 ctrl", rd, 0);
        check(pwm_oe == 1'b0, "R1 oe", pwm_oe, 0);

        // R5 directed corners, code 0 and 255
        reg_write(8'hD8, 8'h00);
        reg_write(8'hD2, 8'h80);
        repeat (2) @(negedge clk);
        measure_high(n); check(n == exp_high(0), "R5 code0", n, exp_high(0));
        reg_write(8'hD8, 8'hFF);
        repeat (2) @(negedge clk);
        measure_high(n); check(n == exp_high(255), "R5 code255", n, exp_high(255));

        // random codes: R2 readback, R3 reserved bits, R5 high time
        for (int k = 0; k < 10; k++) begin
            code = int'($urandom_range(0, 255));
            reg_write(8'hD8, 8'(code));
            reg_write(8'hD2, 8'h80 | 8'($urandom_range(0, 127)));
            reg_read(8'hD8, rd); check(rd == 8'(code), "R2 duty readback", rd, code);
            reg_read(8'hD2, rd); check(rd == 8'h80, "R3 ctrl readback", rd, 8'h80);
            repeat (2) @(negedge clk);
            measure_high(n); check(n == exp_high(code), "R5 high count", n, exp_high(code));
        end

        // R4 unmapped addresses
        reg_write(8'hD8, 8'h5A);
        for (int k = 0; k < 6; k++) begin
            do a = 8'($urandom_range(0, 255)); while (a == 8'hD2 || a == 8'hD8);
            reg_write(a, 8'h00);
            reg_read(a, rd); check(rd == 8'h00, "R4 unmapped read", rd, 0);
        end
        reg_read(8'hD8, rd); check(rd == 8'h5A, "R4 duty untouched", rd, 8'h5A);
        reg_read(8'hD2, rd); check(rd == 8'h80, "R4 ctrl untouched", rd, 8'h80);

        // R7 immediate disable (one clock after write edge)
        reg_write(8'hD8, 8'hFF);
        repeat (3) @(negedge clk);
        check(pwm_oe == 1'b1, "R6 oe while enabled", pwm_oe, 1);
        reg_write(8'hD2, 8'h00);
        check(pwm_oe == 1'b1, "R7 oe before state edge", pwm_oe, 1);
        @(negedge clk);
        check(pwm_oe == 1'b0, "R7 oe one clock after write", pwm_oe, 0);

        // R6 released for a whole period
        errs = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (pwm_oe || pwm_out) errs++;
        end
        check(errs == 0, "R6 released while disabled", errs, 0);

        // R8 period continues while disabled
        reg_write(8'hD8, 8'd10);
        reg_write(8'hD2, 8'h80);
        wait_rise(t0);
        reg_write(8'hD2, 8'h00);
        repeat (777) @(negedge clk);
        reg_write(8'hD2, 8'h80);
        repeat (PER + 5) @(negedge clk);
        wait_rise(t1);
        check(t0 >= 0 && t1 > t0 && ((t1 - t0) % PER) == 0, "R8 phase kept", (t1 - t0) % PER, 0);

        // R1 reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        reg_read(8'hD8, rd); check(rd == 8'h00, "R1 duty after reset", rd, 0);
        reg_read(8'hD2, rd); check(rd == 8'h00, "R1 ctrl after reset", rd, 0);
        @(negedge clk);
        check(pwm_oe == 1'b0, "R1 oe after reset", pwm_oe, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule